// File: doc/BRIEF.md
# Instruction Control Decoder

This block turns three fields of a 32-bit instruction word into the full set of datapath steering lines for a single-cycle 64-bit core. It looks only at the seven-bit major opcode, the three-bit minor function field and bit 30 of the word. From these it drives twelve control lines: the ALU operation, register-file write, operand-A and operand-B source selects, memory read, memory write, write-back source, branch, direct jump, register jump, immediate-format select and an illegal-instruction flag. It holds no state. Each output is a pure function of the present inputs, so every line is valid in the same cycle as the instruction.

The decode has two levels. First, seven comparators work side by side. Each tests the opcode against one instruction group, with an optional mask of bits it does not care about. Next, the minor field and bit 30 narrow the group hit down to an ALU operation and to single-opcode distinctions inside a group. A parameter picks one of two variants. In the strict variant, minor-field values that no instruction defines are rejected. In the lax variant they are accepted.

Top module: `instr_ctrl_decoder`

## Requirements
- R1: All outputs follow a change of `opcode`, `funct3` or `bit30` within the same clock cycle. They depend on no earlier input.
- R2: These opcodes are recognised: 0x33 register ALU, 0x13 immediate ALU, 0x03 load, 0x23 store, 0x63 branch, 0x6F direct jump, 0x67 register jump, 0x37 load-upper, 0x17 PC-relative upper. Any other opcode raises `illegal`.
- R3: For opcode 0x33, `alu_op` follows funct3 as follows: 0 gives ADD(0), or SUB(1) when bit30 is 1. 1 gives SLL(2). 2 gives SLT(3). 3 gives SLTU(4). 4 gives XOR(5). 5 gives SRL(6), or SRA(7) when bit30 is 1. 6 gives OR(8). 7 gives AND(9). The same opcode sets `reg_wr`=1 and `src_b_imm`=0.
- R4: For opcode 0x13, the funct3 map is the same as in R3, except that bit30 matters only when funct3 is 5. The same opcode sets `reg_wr`=1 and `src_b_imm`=1.
- R5: A load sets `reg_wr`, `src_b_imm`, `mem_rd` and `wb_from_mem`, with `alu_op`=ADD and `mem_wr`=0.
- R6: A store sets `mem_wr` and `src_b_imm`, with `alu_op`=ADD and `reg_wr`=0.
- R7: A branch sets `branch`=1 and `reg_wr`=0. Its compare operation comes from funct3[2:1]: 00 or 01 gives SUB(1), 10 gives SLT(3), 11 gives SLTU(4).
- R8: A direct jump sets `jump_pc`, `reg_wr`, `src_a_pc` and `src_b_imm`. A register jump sets `jump_reg`, `reg_wr` and `src_b_imm`, with `src_a_pc`=0. Both use `alu_op`=ADD.
- R9: Load-upper sets `alu_op`=PASSB(10), `reg_wr` and `src_b_imm`. PC-relative upper sets `alu_op`=ADD, `src_a_pc`, `reg_wr` and `src_b_imm`.
- R10: When `illegal` is 1, `reg_wr`, `mem_rd`, `mem_wr`, `wb_from_mem`, `branch`, `jump_pc`, `jump_reg`, `src_a_pc`, `src_b_imm`, `alu_op` and `imm_sel` are all 0.
- R11: With STRICT_F3=1, the following also raise `illegal`: a load with funct3 7, a store with funct3 of 4 or more, a branch with funct3 2 or 3, and a register jump with funct3 not 0. With STRICT_F3=0 these decode as their group.
- R12: `imm_sel` codes are 0 for I-form, 1 for S-form, 2 for B-form, 3 for U-form and 4 for J-form. Register ALU instructions use 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | OPC_W (7) | Major opcode, instruction bits 6:0 |
| funct3 | input | F3_W (3) | Minor function field, instruction bits 14:12 |
| bit30 | input | 1 | Instruction bit 30, selects the alternate ALU operation |
| alu_op | output | ALU_W (4) | ALU operation code |
| reg_wr | output | 1 | Register file write enable |
| src_a_pc | output | 1 | Operand A taken from the program counter |
| src_b_imm | output | 1 | Operand B taken from the immediate |
| mem_rd | output | 1 | Data memory read enable |
| mem_wr | output | 1 | Data memory write enable |
| wb_from_mem | output | 1 | Write-back value comes from memory |
| branch | output | 1 | Conditional branch instruction |
| jump_pc | output | 1 | PC-relative unconditional jump |
| jump_reg | output | 1 | Register-based unconditional jump |
| imm_sel | output | IMM_W (3) | Immediate format select |
| illegal | output | 1 | Unrecognised instruction |

## Verification
The bench builds two copies of the decoder, one with STRICT_F3=1 and one with STRICT_F3=0. This lets each rejected minor-field value be seen both as an illegal instruction and as a member of its group. Both copies keep the default 7-bit opcode and 4-bit ALU code. At those widths the whole 2048-point input space of opcode, funct3 and bit30 can be swept exhaustively. Fields taken from random 32-bit words then check that the other instruction bits have no effect.

// File: rtl/icd_pkg.sv
package icd_pkg;

   localparam int unsigned N_GRP     = 7;
   localparam int unsigned GRP_BITS  = 7;

   // group indices
   localparam int unsigned G_RALU = 0;
   localparam int unsigned G_IALU = 1;
   localparam int unsigned G_LOAD = 2;
   localparam int unsigned G_STOR = 3;
   localparam int unsigned G_BRAN = 4;
   localparam int unsigned G_JUMP = 5;
   localparam int unsigned G_UPPR = 6;

   typedef enum logic [3:0] {
      ALU_ADD   = 4'd0,
      ALU_SUB   = 4'd1,
      ALU_SLL   = 4'd2,
      ALU_SLT   = 4'd3,
      ALU_SLTU  = 4'd4,
      ALU_XOR   = 4'd5,
      ALU_SRL   = 4'd6,
      ALU_SRA   = 4'd7,
      ALU_OR    = 4'd8,
      ALU_AND   = 4'd9,
      ALU_PASSB = 4'd10
   } alu_code_e;

   typedef enum logic [2:0] {
      IMM_I = 3'd0,
      IMM_S = 3'd1,
      IMM_B = 3'd2,
      IMM_U = 3'd3,
      IMM_J = 3'd4
   } imm_form_e;

   // compare value per group after masking
   function automatic logic [GRP_BITS-1:0] grp_value(input int unsigned idx);
      case (idx)
         G_RALU:  return 7'h33;
         G_IALU:  return 7'h13;
         G_LOAD:  return 7'h03;
         G_STOR:  return 7'h23;
         G_BRAN:  return 7'h63;
         G_JUMP:  return 7'h67;  // bit 3 ignored: 0x67 and 0x6F
         default: return 7'h17;  // bit 5 ignored: 0x17 and 0x37
      endcase
   endfunction

   // bits that take part in the compare
   function automatic logic [GRP_BITS-1:0] grp_mask(input int unsigned idx);
      case (idx)
         G_JUMP:  return 7'h77;
         G_UPPR:  return 7'h5F;
         default: return 7'h7F;
      endcase
   endfunction

endpackage

// File: rtl/icd_group_match.sv
module icd_group_match
   import icd_pkg::*;
#(
   parameter int unsigned OPC_W = 7,
   parameter int unsigned NG    = N_GRP
) (
   input  logic [OPC_W-1:0] opc,
   output logic [NG-1:0]    hit
);

   if (OPC_W != GRP_BITS) begin : g_bad_opc_w
      $error("icd_group_match: OPC_W must equal %0d", GRP_BITS);
   end
   if (NG != N_GRP) begin : g_bad_ng
      $error("icd_group_match: NG must equal %0d", N_GRP);
   end

   for (genvar g = 0; g < NG; g++) begin : g_cmp
      localparam logic [OPC_W-1:0] CMP_VAL = OPC_W'(grp_value(g));
      localparam logic [OPC_W-1:0] CMP_MSK = OPC_W'(grp_mask(g));
      assign hit[g] = ((opc & CMP_MSK) == CMP_VAL);
   end

   // R2: the comparators never claim one opcode for two groups
   always_comb begin
      a_r2_group_exclusive: assert ($onehot0(hit))
         else $error("opcode matched more than one group");
   end

endmodule

// File: rtl/icd_alu_sel.sv
module icd_alu_sel
   import icd_pkg::*;
#(
   parameter int unsigned F3_W  = 3,
   parameter int unsigned ALU_W = 4,
   parameter int unsigned NG    = N_GRP
) (
   input  logic [NG-1:0]    hit,
   input  logic [F3_W-1:0]  f3,
   input  logic             alt,
   input  logic             upper_is_lui,
   output logic [ALU_W-1:0] op
);

   localparam int unsigned CODE_W = $bits(alu_code_e);

   if (F3_W != 3) begin : g_bad_f3_w
      $error("icd_alu_sel: F3_W must be 3");
   end
   if (ALU_W < CODE_W) begin : g_bad_alu_w
      $error("icd_alu_sel: ALU_W must be at least %0d", CODE_W);
   end

   alu_code_e arith_code;
   alu_code_e cmp_code;
   alu_code_e code;
   logic      use_alt;

   // bit 30 applies to add/sub only for register ops, to shifts for both
   always_comb begin
      use_alt = alt & (hit[G_RALU] | (f3 == 3'd5));
      case (f3)
         3'd0:    arith_code = use_alt ? ALU_SUB : ALU_ADD;
         3'd1:    arith_code = ALU_SLL;
         3'd2:    arith_code = ALU_SLT;
         3'd3:    arith_code = ALU_SLTU;
         3'd4:    arith_code = ALU_XOR;
         3'd5:    arith_code = use_alt ? ALU_SRA : ALU_SRL;
         3'd6:    arith_code = ALU_OR;
         default: arith_code = ALU_AND;
      endcase
   end

   always_comb begin
      case (f3[2:1])
         2'b10:   cmp_code = ALU_SLT;
         2'b11:   cmp_code = ALU_SLTU;
         default: cmp_code = ALU_SUB;
      endcase
   end

   always_comb begin
      code = ALU_ADD;
      if (hit[G_RALU] | hit[G_IALU]) code = arith_code;
      else if (hit[G_BRAN])          code = cmp_code;
      else if (hit[G_UPPR] & upper_is_lui) code = ALU_PASSB;
   end

   assign op = ALU_W'(code);

   // R7: a branch never asks for an arithmetic or logic op
   always_comb begin
      if (hit[G_BRAN]) begin
         a_r7_branch_compare: assert (code == ALU_SUB || code == ALU_SLT || code == ALU_SLTU)
            else $error("branch decoded to non-compare op");
      end
   end

endmodule

// File: rtl/icd_ctrl_gen.sv
module icd_ctrl_gen
   import icd_pkg::*;
#(
   parameter int unsigned F3_W      = 3,
   parameter int unsigned IMM_W     = 3,
   parameter int unsigned NG        = N_GRP,
   parameter bit          STRICT_F3 = 1'b1
) (
   input  logic [NG-1:0]    hit,
   input  logic [F3_W-1:0]  f3,
   input  logic             jump_is_direct,
   input  logic             upper_is_lui,
   output logic             legal,
   output logic             reg_wr,
   output logic             a_pc,
   output logic             b_imm,
   output logic             mem_rd,
   output logic             mem_wr,
   output logic             wb_mem,
   output logic             br,
   output logic             jmp_pc,
   output logic             jmp_reg,
   output logic [IMM_W-1:0] imm
);

   if (IMM_W < $bits(imm_form_e)) begin : g_bad_imm_w
      $error("icd_ctrl_gen: IMM_W too narrow");
   end

   logic       f3_ok;
   logic       any_hit;
   imm_form_e  form;

   if (STRICT_F3) begin : g_strict
      always_comb begin
         f3_ok = 1'b1;
         if (hit[G_LOAD] && f3 == 3'd7)                     f3_ok = 1'b0;
         if (hit[G_STOR] && f3[2])                          f3_ok = 1'b0;
         if (hit[G_BRAN] && f3[2:1] == 2'b01)               f3_ok = 1'b0;
         if (hit[G_JUMP] && !jump_is_direct && f3 != 3'd0)  f3_ok = 1'b0;
      end
   end else begin : g_lax
      assign f3_ok = 1'b1;
      logic unused_f3;
      assign unused_f3 = ^f3;
   end

   assign any_hit = |hit;
   assign legal   = any_hit & f3_ok;

   always_comb begin
      form = IMM_I;
      if (hit[G_STOR])                         form = IMM_S;
      if (hit[G_BRAN])                         form = IMM_B;
      if (hit[G_UPPR])                         form = IMM_U;
      if (hit[G_JUMP] && jump_is_direct)       form = IMM_J;
   end

   logic upper_pc;
   assign upper_pc = hit[G_UPPR] & ~upper_is_lui;

   always_comb begin
      reg_wr  = legal & (hit[G_RALU] | hit[G_IALU] | hit[G_LOAD] | hit[G_JUMP] | hit[G_UPPR]);
      b_imm   = legal & ~(hit[G_RALU] | hit[G_BRAN]);
      a_pc    = legal & ((hit[G_JUMP] & jump_is_direct) | upper_pc);
      mem_rd  = legal & hit[G_LOAD];
      wb_mem  = legal & hit[G_LOAD];
      mem_wr  = legal & hit[G_STOR];
      br      = legal & hit[G_BRAN];
      jmp_pc  = legal & hit[G_JUMP] & jump_is_direct;
      jmp_reg = legal & hit[G_JUMP] & ~jump_is_direct;
      imm     = legal ? IMM_W'(form) : '0;
   end

   // R10: a rejected word may not change architectural state
   always_comb begin
      if (!legal) begin
         a_r10_no_side_effect: assert (!reg_wr && !mem_wr && !mem_rd && !br && !jmp_pc && !jmp_reg)
            else $error("rejected instruction drives a write or redirect");
      end
   end

   // R6: no instruction writes both memory and register file
   always_comb begin
      a_r6_single_writer: assert (!(mem_wr && reg_wr))
         else $error("memory and register write together");
   end

endmodule

// File: rtl/instr_ctrl_decoder.sv
module instr_ctrl_decoder
   import icd_pkg::*;
#(
   parameter int unsigned OPC_W     = 7,
   parameter int unsigned F3_W      = 3,
   parameter int unsigned ALU_W     = 4,
   parameter int unsigned IMM_W     = 3,
   parameter bit          STRICT_F3 = 1'b1
) (
   input  logic [OPC_W-1:0] opcode,
   input  logic [F3_W-1:0]  funct3,
   input  logic             bit30,
   output logic [ALU_W-1:0] alu_op,
   output logic             reg_wr,
   output logic             src_a_pc,
   output logic             src_b_imm,
   output logic             mem_rd,
   output logic             mem_wr,
   output logic             wb_from_mem,
   output logic             branch,
   output logic             jump_pc,
   output logic             jump_reg,
   output logic [IMM_W-1:0] imm_sel,
   output logic             illegal
);

   localparam int unsigned JUMP_BIT  = 3;
   localparam int unsigned UPPER_BIT = 5;

   if (OPC_W <= UPPER_BIT) begin : g_bad_opc
      $error("instr_ctrl_decoder: OPC_W too narrow");
   end

   logic [N_GRP-1:0] grp_hit;
   logic [ALU_W-1:0] alu_raw;
   logic             legal;

   icd_group_match #(
      .OPC_W (OPC_W),
      .NG    (N_GRP)
   ) u_match (
      .opc (opcode),
      .hit (grp_hit)
   );

   icd_alu_sel #(
      .F3_W  (F3_W),
      .ALU_W (ALU_W),
      .NG    (N_GRP)
   ) u_alu (
      .hit          (grp_hit),
      .f3           (funct3),
      .alt          (bit30),
      .upper_is_lui (opcode[UPPER_BIT]),
      .op           (alu_raw)
   );

   icd_ctrl_gen #(
      .F3_W      (F3_W),
      .IMM_W     (IMM_W),
      .NG        (N_GRP),
      .STRICT_F3 (STRICT_F3)
   ) u_ctrl (
      .hit            (grp_hit),
      .f3             (funct3),
      .jump_is_direct (opcode[JUMP_BIT]),
      .upper_is_lui   (opcode[UPPER_BIT]),
      .legal          (legal),
      .reg_wr         (reg_wr),
      .a_pc           (src_a_pc),
      .b_imm          (src_b_imm),
      .mem_rd         (mem_rd),
      .mem_wr         (mem_wr),
      .wb_mem         (wb_from_mem),
      .br             (branch),
      .jmp_pc         (jump_pc),
      .jmp_reg        (jump_reg),
      .imm            (imm_sel)
   );

   assign illegal = ~legal;
   assign alu_op  = legal ? alu_raw : '0;

   // R5: a memory read always returns its data to the register file
   always_comb begin
      if (mem_rd) begin
         a_r5_load_writeback: assert (wb_from_mem && reg_wr && !mem_wr)
            else $error("load without register write-back");
      end
   end

   // R8: jumps always link and never coincide with a branch
   always_comb begin
      if (jump_pc || jump_reg) begin
         a_r8_jump_links: assert (reg_wr && !branch && !(jump_pc && jump_reg))
            else $error("jump decode inconsistent");
      end
   end

   // R7: a conditional branch never writes the register file
   always_comb begin
      if (branch) begin
         a_r7_branch_no_write: assert (!reg_wr && !mem_wr)
            else $error("branch with a write enable");
      end
   end

endmodule

// File: tb/instr_ctrl_decoder_test.sv
module instr_ctrl_decoder_test;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2 clk = ~clk;

   logic [6:0] opcode;
   logic [2:0] funct3;
   logic       bit30;

   logic [3:0] s_alu, l_alu;
   logic       s_rw, s_apc, s_bim, s_mrd, s_mwr, s_wbm, s_br, s_jp, s_jr, s_ill;
   logic       l_rw, l_apc, l_bim, l_mrd, l_mwr, l_wbm, l_br, l_jp, l_jr, l_ill;
   logic [2:0] s_imm, l_imm;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   instr_ctrl_decoder #(.STRICT_F3(1'b1)) uut (
      .opcode(opcode), .funct3(funct3), .bit30(bit30),
      .alu_op(s_alu), .reg_wr(s_rw), .src_a_pc(s_apc), .src_b_imm(s_bim),
      .mem_rd(s_mrd), .mem_wr(s_mwr), .wb_from_mem(s_wbm), .branch(s_br),
      .jump_pc(s_jp), .jump_reg(s_jr), .imm_sel(s_imm), .illegal(s_ill)
   );

   instr_ctrl_decoder #(.STRICT_F3(1'b0)) uut_lax (
      .opcode(opcode), .funct3(funct3), .bit30(bit30),
      .alu_op(l_alu), .reg_wr(l_rw), .src_a_pc(l_apc), .src_b_imm(l_bim),
      .mem_rd(l_mrd), .mem_wr(l_mwr), .wb_from_mem(l_wbm), .branch(l_br),
      .jump_pc(l_jp), .jump_reg(l_jr), .imm_sel(l_imm), .illegal(l_ill)
   );

   // vector layout: [3:0] alu, 4 rw, 5 apc, 6 bimm, 7 mrd, 8 mwr, 9 wbm,
   // 10 br, 11 jpc, 12 jreg, [15:13] imm, 16 illegal
   function automatic logic [16:0] pack(input logic [3:0] a, input logic rw, apc, bim,
                                        mrd, mwr, wbm, br, jp, jr,
                                        input logic [2:0] im, input logic il);
      return {il, im, jr, jp, br, wbm, mwr, mrd, bim, apc, rw, a};
   endfunction

   function automatic logic [3:0] arith_ref(input logic [2:0] f, input logic alt, input logic reg_form);
      logic [3:0] r;
      case (f)
         3'd0: r = (alt && reg_form) ? 4'd1 : 4'd0;
         3'd1: r = 4'd2;
         3'd2: r = 4'd3;
         3'd3: r = 4'd4;
         3'd4: r = 4'd5;
         3'd5: r = alt ? 4'd7 : 4'd6;
         3'd6: r = 4'd8;
         default: r = 4'd9;
      endcase
      return r;
   endfunction

   function automatic logic [16:0] expect_vec(input logic [6:0] o, input logic [2:0] f,
                                              input logic alt, input bit strict);
      logic [16:0] v;
      logic ok;
      v  = 17'h10000;   // illegal, everything else low
      ok = 1'b1;
      case (o)
         7'h33: v = pack(arith_ref(f, alt, 1'b1), 1,0,0, 0,0,0, 0,0,0, 3'd0, 0);
         7'h13: v = pack(arith_ref(f, alt, 1'b0), 1,0,1, 0,0,0, 0,0,0, 3'd0, 0);
         7'h03: begin ok = !(strict && f == 3'd7);
                      v = pack(4'd0, 1,0,1, 1,0,1, 0,0,0, 3'd0, 0); end
         7'h23: begin ok = !(strict && f >= 3'd4);
                      v = pack(4'd0, 0,0,1, 0,1,0, 0,0,0, 3'd1, 0); end
         7'h63: begin ok = !(strict && (f == 3'd2 || f == 3'd3));
                      v = pack((f >= 3'd6) ? 4'd4 : (f >= 3'd4) ? 4'd3 : 4'd1,
                               0,0,0, 0,0,0, 1,0,0, 3'd2, 0); end
         7'h6F: v = pack(4'd0, 1,1,1, 0,0,0, 0,1,0, 3'd4, 0);
         7'h67: begin ok = !(strict && f != 3'd0);
                      v = pack(4'd0, 1,0,1, 0,0,0, 0,0,1, 3'd0, 0); end
         7'h37: v = pack(4'd10, 1,0,1, 0,0,0, 0,0,0, 3'd3, 0);
         7'h17: v = pack(4'd0, 1,1,1, 0,0,0, 0,0,0, 3'd3, 0);
         default: ok = 1'b0;
      endcase
      if (!ok) v = 17'h10000;
      return v;
   endfunction

   function automatic string grp_tag(input logic [6:0] o);
      case (o)
         7'h33: return "R3";
         7'h13: return "R4";
         7'h03: return "R5";
         7'h23: return "R6";
         7'h63: return "R7";
         7'h6F, 7'h67: return "R8";
         7'h37, 7'h17: return "R9";
         default: return "R2";
      endcase
   endfunction

   task automatic chk(input string req, input string what, input logic [16:0] got, input logic [16:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s op=%h f3=%0d b30=%0b actual=%h expected=%h",
                  req, what, opcode, funct3, bit30, got, exp);
      end
   endtask

   task automatic compare_both();
      logic [16:0] gs, gl, es, el;
      string tag, itag;
      gs = pack(s_alu, s_rw, s_apc, s_bim, s_mrd, s_mwr, s_wbm, s_br, s_jp, s_jr, s_imm, s_ill);
      gl = pack(l_alu, l_rw, l_apc, l_bim, l_mrd, l_mwr, l_wbm, l_br, l_jp, l_jr, l_imm, l_ill);
      es = expect_vec(opcode, funct3, bit30, 1'b1);
      el = expect_vec(opcode, funct3, bit30, 1'b0);
      tag  = grp_tag(opcode);
      // a group opcode rejected only by the strict copy is an R11 case
      itag = (es[16] && !el[16]) ? "R11" : "R2";
      chk(es[16] ? "R10" : tag, "strict alu/ctrl", {5'd0, gs[12:0]}, {5'd0, es[12:0]});
      chk("R12", "strict imm_sel", {14'd0, gs[15:13]}, {14'd0, es[15:13]});
      chk(itag,  "strict illegal", {16'd0, gs[16]}, {16'd0, es[16]});
      chk(el[16] ? "R10" : tag, "lax alu/ctrl", {5'd0, gl[12:0]}, {5'd0, el[12:0]});
      chk("R12", "lax imm_sel", {14'd0, gl[15:13]}, {14'd0, el[15:13]});
      chk(itag,  "lax illegal", {16'd0, gl[16]}, {16'd0, el[16]});
   endtask

   task automatic apply(input logic [6:0] o, input logic [2:0] f, input logic b);
      @(negedge clk);
      opcode = o; funct3 = f; bit30 = b;
      #1;
      compare_both();
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] word;
      void'($urandom(32'd4711));
      opcode = 7'h00; funct3 = 3'd0; bit30 = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      // R2: the all-zero word held during reset is not an instruction
      chk("R2", "reset-state illegal", {16'd0, s_ill}, 17'd1);
      rst = 1'b0;

      // R1: a new word decodes in the same cycle it is presented
      @(negedge clk);
      opcode = 7'h33; funct3 = 3'd0; bit30 = 1'b1;
      #1;
      chk("R1", "same-cycle sub", {13'd0, s_alu}, 17'd1);
      opcode = 7'h23; funct3 = 3'd2;
      #0.5;
      chk("R1", "same-cycle store", {16'd0, s_mwr}, 17'd1);

      // directed corners
      apply(7'h13, 3'd0, 1'b1);   // R4: add-immediate ignores bit30
      apply(7'h13, 3'd5, 1'b1);   // R4: arithmetic right shift
      apply(7'h37, 3'd6, 1'b1);   // R9: load-upper
      apply(7'h63, 3'd3, 1'b0);   // R11: reserved branch kind
      apply(7'h67, 3'd1, 1'b0);   // R11: register jump bad minor field
      apply(7'h7F, 3'd0, 1'b0);   // R10: unknown opcode

      // exhaustive sweep of every opcode/funct3/bit30 combination
      for (int i = 0; i < 2048; i++) begin
         apply(i[10:4], i[3:1], i[0]);
      end

      // random whole words: only the three fields may matter
      for (int k = 0; k < 600; k++) begin
         word = $urandom();
         if (k[0]) word[6:0] = {word[6:4] & 3'b110, 4'b0011} | {word[4], 6'd0};
         apply(word[6:0], word[14:12], word[30]);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule